// File: doc/BRIEF.md
# Interrupt Acknowledge Vector Sequencer

This block answers the processor's interrupt acknowledge pulses by placing bytes on the data bus. A resolver elsewhere has already picked the winning request. That request arrives here as a 3-bit level code, together with the programmed address and type fields. One mode input chooses between two response protocols.

In three-cycle mode, three acknowledge pulses make up one sequence. The first pulse carries a call opcode. The second carries the low byte of the handler address, with the level code inserted at a position set by the interval select. The third carries the programmed page byte.

In two-cycle mode, the first pulse places nothing on the bus. It only raises a freeze strobe, so that the request state can be held for resolution. The second pulse returns one vector byte built from the type tag and the level code.

A pulse counter steps on the falling edge of each acknowledge pulse. It returns to zero after the last pulse of the selected mode. Reset aborts a sequence that is in progress.

Top module: `ack_vector_seq`

## Requirements
- R1: During and right after reset, `bus_oe` is 0, `bus_data` is 8'h00 and `freeze` is 0, even while `ack` is held high; the next pulse is treated as the first of a sequence.
- R2: In three-cycle mode (`resp_two`=0), the first pulse drives the call opcode 8'hCD with `bus_oe`=1.
- R3: In three-cycle mode with `intv8`=0, the second pulse drives {vec_base[2:0], level[2:0], 2'b00}.
- R4: In three-cycle mode with `intv8`=1, the second pulse drives {vec_base[2:1], level[2:0], 3'b000}; `vec_base[0]` has no effect.
- R5: In three-cycle mode, the third pulse drives `addr_page[7:0]`.
- R6: After the final pulse of the selected mode (the third in three-cycle mode, the second in two-cycle mode), the next pulse is again the first of a sequence.
- R7: In two-cycle mode (`resp_two`=1), the first pulse keeps `bus_oe` at 0 and `bus_data` at 8'h00, and raises `freeze`.
- R8: In two-cycle mode, the second pulse drives {type_tag[4:0], level[2:0]}; `intv8`, `vec_base` and `addr_page` have no effect.
- R9: `bus_oe` is 1 only while `ack` is high on a data-carrying pulse; whenever `bus_oe` is 0, `bus_data` is 8'h00.
- R10: The pulse position advances only on the falling edge of `ack`. While `ack` stays high, the driven byte does not change.
- R11: Asserting `rst_n` low in the middle of a sequence aborts it. The next pulse after release is a first pulse.
- R12: `freeze` is high only in the first clock cycle of the first pulse of a sequence (from the rising edge of `ack` to the next clock edge), in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `ack` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack | input | 1 | Acknowledge strobe, active high |
| resp_two | input | 1 | 1 = two-cycle protocol, 0 = three-cycle protocol |
| intv8 | input | 1 | 1 = interval 8 placement, 0 = interval 4 placement |
| level | input | 3 | Level code of the winning request |
| vec_base | input | 3 | Programmed address bits 7..5 |
| addr_page | input | 8 | Programmed address bits 15..8 |
| type_tag | input | 5 | Programmed type bits 7..3 |
| bus_data | output | 8 | Byte driven toward the processor |
| bus_oe | output | 1 | Data-bus enable |
| freeze | output | 1 | Request-freeze strobe |

## Verification
The only state in the block is the pulse position, so any fault in it shows up as a wrong byte at the ports. A counter that is off by one puts the opcode, the vector or the page byte on the wrong pulse. In two-cycle mode the same fault also makes data appear on the quiet first pulse. A counter that skips its wrap, or that does not clear on reset, misplaces the first byte of the following sequence. Each of these faults shows up on the very next pulse that the bench issues.

// File: rtl/ackv_pkg.sv
package ackv_pkg;
   typedef enum logic {RESP_THREE = 1'b0, RESP_TWO = 1'b1} resp_mode_e;
   localparam int IDX_W = 2;
   typedef logic [IDX_W-1:0] pulse_idx_t;
   localparam pulse_idx_t IDX_FIRST = 2'd0;
   localparam pulse_idx_t IDX_SECOND = 2'd1;
   localparam pulse_idx_t IDX_THIRD = 2'd2;
endpackage

// File: rtl/ackv_strobe.sv
module ackv_strobe (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic rise,
   output logic fall
);
   logic ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= ack;
   end

   assign rise = ack & ~ack_q;
   assign fall = ~ack & ack_q;
endmodule

// File: rtl/ackv_pulse_ctr.sv
module ackv_pulse_ctr
   import ackv_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fall,
   input  resp_mode_e mode,
   output pulse_idx_t idx,
   output logic       last
);
   assign last = (mode == RESP_TWO) ? (idx == IDX_SECOND) : (idx == IDX_THIRD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx <= IDX_FIRST;
      else if (fall) idx <= last ? IDX_FIRST : idx + 2'd1;
   end
endmodule

// File: rtl/ackv_vector_mux.sv
module ackv_vector_mux
   import ackv_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LVL_W = 3,
   parameter logic [DATA_W-1:0] CALL_OP = 8'hCD
) (
   input  resp_mode_e              mode,
   input  pulse_idx_t              idx,
   input  logic                    intv8,
   input  logic [LVL_W-1:0]        level,
   input  logic [DATA_W-LVL_W-3:0] vec_base,
   input  logic [DATA_W-1:0]       addr_page,
   input  logic [DATA_W-LVL_W-1:0] type_tag,
   output logic [DATA_W-1:0]       byte_out,
   output logic                    carries
);
   localparam int HI4 = DATA_W - LVL_W - 2;
   localparam int HI8 = DATA_W - LVL_W - 3;

   logic [DATA_W-1:0] low_vec;

   generate
      if (HI8 >= 1) begin : g_place
         always_comb begin
            if (intv8) low_vec = {vec_base[HI4-1 -: HI8], level, 3'b000};
            else       low_vec = {vec_base, level, 2'b00};
         end
      end else begin : g_place_bad
         assign low_vec = '0;
      end
   endgenerate

   always_comb begin
      byte_out = '0;
      carries  = 1'b0;
      if (mode == RESP_TWO) begin
         if (idx == IDX_SECOND) begin
            byte_out = {type_tag, level};
            carries  = 1'b1;
         end
      end else begin
         case (idx)
            IDX_FIRST:  begin byte_out = CALL_OP;   carries = 1'b1; end
            IDX_SECOND: begin byte_out = low_vec;   carries = 1'b1; end
            IDX_THIRD:  begin byte_out = addr_page; carries = 1'b1; end
            default:    begin byte_out = '0;        carries = 1'b0; end
         endcase
      end
   end
endmodule

// File: rtl/ack_vector_seq.sv
module ack_vector_seq
   import ackv_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int LVL_W = 3,
   parameter logic [DATA_W-1:0] CALL_OP = 8'hCD
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ack,
   input  logic                    resp_two,
   input  logic                    intv8,
   input  logic [LVL_W-1:0]        level,
   input  logic [DATA_W-LVL_W-3:0] vec_base,
   input  logic [DATA_W-1:0]       addr_page,
   input  logic [DATA_W-LVL_W-1:0] type_tag,
   output logic [DATA_W-1:0]       bus_data,
   output logic                    bus_oe,
   output logic                    freeze
);
   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("ack_vector_seq: DATA_W must be 8");
      end
      if (LVL_W != 3) begin : g_bad_level
         $error("ack_vector_seq: LVL_W must be 3");
      end
   endgenerate

   resp_mode_e        mode;
   logic              ack_rise, ack_fall, seq_last, carries;
   pulse_idx_t        pulse_idx;
   logic [DATA_W-1:0] sel_byte;

   assign mode = resp_two ? RESP_TWO : RESP_THREE;

   ackv_strobe u_strobe (
      .clk(clk), .rst_n(rst_n), .ack(ack), .rise(ack_rise), .fall(ack_fall)
   );

   ackv_pulse_ctr u_ctr (
      .clk(clk), .rst_n(rst_n), .fall(ack_fall), .mode(mode),
      .idx(pulse_idx), .last(seq_last)
   );

   ackv_vector_mux #(.DATA_W(DATA_W), .LVL_W(LVL_W), .CALL_OP(CALL_OP)) u_mux (
      .mode(mode), .idx(pulse_idx), .intv8(intv8), .level(level),
      .vec_base(vec_base), .addr_page(addr_page), .type_tag(type_tag),
      .byte_out(sel_byte), .carries(carries)
   );

   assign bus_oe   = rst_n & ack & carries;
   assign bus_data = bus_oe ? sel_byte : '0;
   assign freeze   = rst_n & ack_rise & (pulse_idx == IDX_FIRST);
endmodule

// File: rtl/ackv_chk.sv
module ackv_chk
   import ackv_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] CALL_OP = 8'hCD
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack,
   input logic              resp_two,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_oe,
   input logic              freeze,
   input pulse_idx_t        pulse_idx,
   input logic              ack_fall,
   input logic              seq_last
);
   AST_OE_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> ack); // R9
   AST_QUIET_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_oe |-> bus_data == '0); // R9
   AST_CALL_ON_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && !resp_two && pulse_idx == IDX_FIRST) |-> bus_data == CALL_OP); // R2
   AST_TWO_FIRST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && resp_two && pulse_idx == IDX_FIRST) |-> !bus_oe); // R7
   AST_FREEZE_FIRST_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> (ack && pulse_idx == IDX_FIRST)); // R12
   AST_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && $past(ack)) |-> $stable(pulse_idx)); // R10
   AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fall && seq_last) |=> pulse_idx == IDX_FIRST); // R6
   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_idx != 2'd3); // R6
endmodule

bind ack_vector_seq ackv_chk #(.DATA_W(DATA_W), .CALL_OP(CALL_OP)) u_chk (
   .clk(clk), .rst_n(rst_n), .ack(ack), .resp_two(resp_two),
   .bus_data(bus_data), .bus_oe(bus_oe), .freeze(freeze),
   .pulse_idx(pulse_idx), .ack_fall(ack_fall), .seq_last(seq_last)
);

// File: tb/sim_ack_vector_seq.sv
module sim_ack_vector_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ack = 1'b0, resp_two = 1'b0, intv8 = 1'b0;
   logic [2:0] level = '0, vec_base = '0;
   logic [7:0] addr_page = '0;
   logic [4:0] type_tag = '0;
   logic [7:0] bus_data;
   logic       bus_oe, freeze;
   int         n_chk = 0, n_fail = 0;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   ack_vector_seq u0 (
      .clk(clk), .rst_n(rst_n), .ack(ack), .resp_two(resp_two), .intv8(intv8),
      .level(level), .vec_base(vec_base), .addr_page(addr_page),
      .type_tag(type_tag), .bus_data(bus_data), .bus_oe(bus_oe), .freeze(freeze)
   );

   // {two, i8, level, vec_base, addr_page, type_tag, expected vector byte}
   localparam logic [28:0] VEC [8] = '{
      {1'b0, 1'b0, 3'd5, 3'b101, 8'h12, 5'b00000, 8'hB4},
      {1'b0, 1'b1, 3'd6, 3'b011, 8'hA5, 5'b11111, 8'h70},
      {1'b0, 1'b0, 3'd0, 3'b111, 8'hFF, 5'b00000, 8'hE0},
      {1'b0, 1'b1, 3'd7, 3'b100, 8'h00, 5'b00000, 8'hB8},
      {1'b1, 1'b0, 3'd3, 3'b000, 8'h00, 5'b10101, 8'hAB},
      {1'b1, 1'b1, 3'd3, 3'b111, 8'hFF, 5'b10101, 8'hAB},
      {1'b1, 1'b0, 3'd7, 3'b010, 8'h5A, 5'b00000, 8'h07},
      {1'b1, 1'b1, 3'd0, 3'b101, 8'hC3, 5'b11111, 8'hF8}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One acknowledge pulse: two clocks high, then one low.
   task automatic pulse(input bit e_oe, input logic [7:0] e_d, input bit e_fz, input string req);
      @(negedge clk); ack = 1'b1; #5;
      chk({req, " freeze"}, freeze, e_fz);
      chk({req, " oe"}, bus_oe, e_oe);
      chk({req, " data"}, bus_data, e_oe ? e_d : 8'h00);
      @(negedge clk); #5;
      chk("R12 freeze one cycle", freeze, 0);
      chk("R10 oe held", bus_oe, e_oe);
      chk("R10 data held", bus_data, e_oe ? e_d : 8'h00);
      @(negedge clk); ack = 1'b0; #5;
      chk("R9 oe low", bus_oe, 0);
      chk("R9 data zero", bus_data, 0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1: reset with ack held high
      ack = 1'b1;
      repeat (2) @(negedge clk);
      #5;
      chk("R1 oe in reset", bus_oe, 0);
      chk("R1 data in reset", bus_data, 0);
      chk("R1 freeze in reset", freeze, 0);
      ack = 1'b0;
      @(negedge clk); rst_n = 1'b1;

      foreach (VEC[i]) begin
         logic [28:0] v;
         v = VEC[i];
         @(negedge clk);
         resp_two = v[28]; intv8 = v[27]; level = v[26:24]; vec_base = v[23:21];
         addr_page = v[20:13]; type_tag = v[12:8];
         if (!v[28]) begin
            pulse(1'b1, 8'hCD, 1'b1, "R2");
            pulse(1'b1, v[7:0], 1'b0, v[27] ? "R4" : "R3");
            pulse(1'b1, v[20:13], 1'b0, "R5");
         end else begin
            pulse(1'b0, 8'h00, 1'b1, "R7");
            pulse(1'b1, v[7:0], 1'b0, "R8");
         end
      end

      // R6: wrap in both modes
      @(negedge clk); resp_two = 1'b0; intv8 = 1'b0; vec_base = 3'b001; level = 3'd2; addr_page = 8'h3C;
      pulse(1'b1, 8'hCD, 1'b1, "R6");
      pulse(1'b1, 8'h28, 1'b0, "R3");
      pulse(1'b1, 8'h3C, 1'b0, "R5");
      pulse(1'b1, 8'hCD, 1'b1, "R6");
      // R11: abort in the middle of the three-cycle sequence
      @(negedge clk); rst_n = 1'b0; ack = 1'b1; #5;
      chk("R11 oe in reset", bus_oe, 0);
      @(negedge clk); ack = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      pulse(1'b1, 8'hCD, 1'b1, "R11");
      // R6/R11 in two-cycle mode
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; resp_two = 1'b1; type_tag = 5'b01100; level = 3'd1;
      pulse(1'b0, 8'h00, 1'b1, "R7");
      pulse(1'b1, 8'h61, 1'b0, "R8");
      pulse(1'b0, 8'h00, 1'b1, "R6");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      pulse(1'b0, 8'h00, 1'b1, "R11");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule